// File: doc/BRIEF.md
# Shadow control register on the boot-ROM address range

This block is an 8-bit control register inside the glue chip of a small Z80-based computer. It sits on one address inside the low ROM range. Address decoding there is incomplete, so the ROM is enabled on every access to that range. The register therefore takes a write straight from the CPU data bus, whatever the ROM happens to drive at the same time.

The chip cannot drive a data line high; it can only pull a line low. A read of the register is built on top of a ROM byte whose bits are 1: every line whose register bit is 0 is pulled low. The bus then carries the register value. Opcode fetches and refresh cycles are left alone, so the CPU still executes the real ROM byte and character data is still fetched during refresh. The value after reset, all zeros, selects the plain operating mode. Other values switch on extended features in the rest of the chip.

The bus side uses plain Z80 strobes, not a valid/ready stream. The CPU sets the pace of every cycle and cannot be held off, so the block never applies back-pressure. It must accept a write within one strobe.

Top module: `rom_cfg_latch`

## Requirements
- R1: While reset is held and after it is released, `ctrl_q` is 8'h00 and `pull_en` is 8'h00.
- R2: A write cycle has `mreq_n`=0, `wr_n`=0 and `addr`=REG_ADDR (default 16'h0065). `din` is sampled on every clock edge while that strobe is seen. `ctrl_q` takes the last sampled value on the first clock edge at which the strobe is no longer seen.
- R3: A write to any other address leaves `ctrl_q` unchanged. This includes the discard targets at addresses 0 to 4.
- R4: A read cycle has `mreq_n`=0, `rd_n`=0, `m1_n`=1, `rfsh_n`=1 and `addr`=REG_ADDR. During it, `pull_en[i]` is 1 exactly when `ctrl_q[i]`=0 and ROM_BYTE[i]=1. The wired-AND bus `rom & ~pull_en` then equals `ctrl_q & ROM_BYTE`. With the default ROM_BYTE 8'hFF, that is `ctrl_q`.
- R5: While `m1_n`=0, `pull_en` is 8'h00, so an opcode fetch from the register address returns the unmodified ROM byte.
- R6: While `rfsh_n`=0, `pull_en` is 8'h00, so a refresh cycle leaves the bus untouched.
- R7: `pull_en` is 8'h00 in any cycle that is not a read cycle as defined in R4. That covers other addresses, `rd_n`=1 and `mreq_n`=1.
- R8: A read in the cycle right after a write strobe ends shows the old register value until the commit edge of R2, and the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, all state on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address bus |
| din | input | 8 | CPU data bus as driven by the CPU |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch cycle, active low |
| rfsh_n | input | 1 | Refresh cycle, active low |
| ctrl_q | output | 8 | Latched control byte |
| pull_en | output | 8 | Per-line open-drain pull-down enable |

## Verification
Two functions can land in the same cycle: the commit of a finished write and a read-back issued straight after it. The bench ends a write strobe and asserts a read in the same half-cycle. It samples the modelled bus just before the commit edge, where it expects the old byte, and again just after, where it expects the new one. Random read cycles also mix M1 and refresh with matching addresses, so the pull-down gating meets the register in every state that random writes leave it in.

// File: rtl/rom_cfg_pkg.sv
package rom_cfg_pkg;
  localparam int unsigned BUS_AW = 16;
  localparam int unsigned BUS_DW = 8;
  typedef logic [BUS_DW-1:0] byte_t;
endpackage

// File: rtl/rom_cfg_decode.sv
module rom_cfg_decode #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] HIT_ADDR = 16'h0065
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb hit = (addr == HIT_ADDR);
endmodule

// File: rtl/rom_cfg_store.sv
module rom_cfg_store #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] ctrl_q
);
  logic [DW-1:0] hold_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else if (strobe) begin
      hold_q <= din;
      pend_q <= 1'b1;
    end else if (pend_q) begin
      ctrl_q <= hold_q;
      pend_q <= 1'b0;
    end
  end

  // register only moves on the edge that follows a seen strobe
  assert_commit_only_after_strobe_R2: assert property (
    @(posedge clk) disable iff (!rst_n) !pend_q |=> $stable(ctrl_q));
  assert_commit_value_R2: assert property (
    @(posedge clk) disable iff (!rst_n) (pend_q && !strobe) |=> (ctrl_q == $past(hold_q)));
endmodule

// File: rtl/rom_cfg_pull.sv
module rom_cfg_pull #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] ROM_BYTE = 8'hFF
) (
  input  logic          rd_act,
  input  logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] pull_en
);
  for (genvar i = 0; i < DW; i++) begin : g_line
    if (ROM_BYTE[i]) begin : g_pull
      always_comb pull_en[i] = rd_act & ~ctrl_q[i];
    end else begin : g_zero
      always_comb pull_en[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rom_cfg_latch.sv
module rom_cfg_latch
  import rom_cfg_pkg::*;
#(
  parameter int unsigned AW = BUS_AW,
  parameter int unsigned DW = BUS_DW,
  parameter logic [AW-1:0] REG_ADDR = 16'h0065,
  parameter logic [DW-1:0] ROM_BYTE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          mreq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          m1_n,
  input  logic          rfsh_n,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] pull_en
);
  logic hit, wr_act, rd_act;

  rom_cfg_decode #(.AW(AW), .HIT_ADDR(REG_ADDR)) u_dec (.addr(addr), .hit(hit));

  always_comb begin
    wr_act = hit & ~mreq_n & ~wr_n;
    rd_act = hit & ~mreq_n & ~rd_n & m1_n & rfsh_n;
  end

  rom_cfg_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .strobe(wr_act), .din(din), .ctrl_q(ctrl_q));

  rom_cfg_pull #(.DW(DW), .ROM_BYTE(ROM_BYTE)) u_pull (
    .rd_act(rd_act), .ctrl_q(ctrl_q), .pull_en(pull_en));

  assert_low_addr_no_hit_R3: assert property (
    @(posedge clk) disable iff (!rst_n) (addr < 5) |-> !hit);
  assert_fetch_quiet_R5: assert property (
    @(posedge clk) disable iff (!rst_n) !m1_n |-> (pull_en == '0));
  assert_refresh_quiet_R6: assert property (
    @(posedge clk) disable iff (!rst_n) !rfsh_n |-> (pull_en == '0));
  assert_idle_quiet_R7: assert property (
    @(posedge clk) disable iff (!rst_n) (mreq_n || rd_n || addr != REG_ADDR) |-> (pull_en == '0));
  assert_readback_bus_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
      (!mreq_n && !rd_n && m1_n && rfsh_n && addr == REG_ADDR)
      |-> ((ROM_BYTE & ~pull_en) == (ctrl_q & ROM_BYTE)));
endmodule

// File: tb/rom_cfg_latch_bench.sv
module rom_cfg_latch_bench;
  localparam logic [15:0] RADDR = 16'h0065;
  localparam logic [7:0]  ROMB  = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic mreq_n = 1, rd_n = 1, wr_n = 1, m1_n = 1, rfsh_n = 1;
  logic [7:0] ctrl_q, pull_en;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_ctrl = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  rom_cfg_latch u_rom_cfg_latch (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mreq_n(mreq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n),
    .ctrl_q(ctrl_q), .pull_en(pull_en));

  function automatic logic [7:0] bus_of(input logic [7:0] pe);
    return ROMB & ~pe;
  endfunction

  function automatic logic [7:0] exp_pull(input logic [15:0] a, input logic mq, rd, m1, rf,
                                          input logic [7:0] c);
    if (!mq && !rd && m1 && rf && a == RADDR) return ~c & ROMB;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    addr = a; din = d; mreq_n = 0; wr_n = 0;
    @(negedge clk);
    mreq_n = 1; wr_n = 1; din = ~d;
    @(negedge clk);
    if (a == RADDR) exp_ctrl = d;
    check(req, ctrl_q, exp_ctrl);
  endtask

  task automatic bus_read(input logic [15:0] a, input logic mq, rd, m1, rf, input string req);
    @(negedge clk);
    addr = a; mreq_n = mq; rd_n = rd; m1_n = m1; rfsh_n = rf;
    #2;
    check(req, pull_en, exp_pull(a, mq, rd, m1, rf, exp_ctrl));
    if (!mq && !rd && m1 && rf && a == RADDR) check({req, " bus"}, bus_of(pull_en), exp_ctrl);
    @(negedge clk);
    mreq_n = 1; rd_n = 1; m1_n = 1; rfsh_n = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check("R1 reset ctrl", ctrl_q, 8'h00);
    check("R1 reset pull", pull_en, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", ctrl_q, 8'h00);

    bus_write(RADDR, 8'hA5, "R2 write");
    bus_read(RADDR, 0, 0, 1, 1, "R4 readback");
    for (int a = 0; a < 5; a++) bus_write(16'(a), 8'h3C, "R3 discard target");
    bus_read(RADDR, 0, 0, 0, 1, "R5 opcode fetch");
    bus_read(RADDR, 0, 0, 1, 0, "R6 refresh");
    bus_read(RADDR, 1, 0, 1, 1, "R7 no mreq");
    bus_read(16'h0066, 0, 0, 1, 1, "R7 other addr");

    // R8: write ends and read starts in the same half-cycle
    @(negedge clk);
    addr = RADDR; din = 8'h0F; mreq_n = 0; wr_n = 0;
    @(negedge clk);
    wr_n = 1; rd_n = 0; din = 8'hFF;
    #2;
    check("R8 before commit", bus_of(pull_en), exp_ctrl);
    @(posedge clk); #1;
    exp_ctrl = 8'h0F;
    check("R8 after commit", bus_of(pull_en), exp_ctrl);
    @(negedge clk);
    mreq_n = 1; rd_n = 1;

    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 3);
      logic [15:0] a;
      int unsigned sel = $urandom_range(0, 2);
      a = (sel == 0) ? RADDR : (sel == 1) ? 16'($urandom_range(0, 4)) : 16'($urandom);
      if (op == 0) bus_write(a, 8'($urandom), "R2/R3 random write");
      else bus_read(a, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                    1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
                    "R4-R7 random read");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule